// File: doc/BRIEF.md
# Upstream Buffer Ring Manager

This block moves one device-to-host data stream into a ring of host memory buffers. Words arrive on a valid/ready input and are written, one per cycle, through a plain address/data write port. The address is the concatenation of the current buffer index and the word offset inside that buffer. Buffer count and buffer length are powers of two. When a buffer completes, the block hands it to the host with a release message that carries the buffer index and the number of valid bytes. The host can also ask for a partly filled buffer to be handed over early, by pulsing a flush request.

Released buffers stay locked until the host returns them with a free command. Free commands must follow the order in which buffers were released. When every buffer is locked, the input stalls. Each time the channel goes from holding nothing to holding data, the block queues a one-time not-empty notice, which a parameter can disable.

All notices leave on a valid/ready message port that feeds the control channel. Once presented, a message holds its kind, buffer and byte count unchanged until `msg_ready` is high. A pending release stalls the input until the release has moved into the output register. In synchronous mode, the input takes only as many bytes as the host has requested through read credits.

Top module: `up_ring_mgr`

## Requirements
- R1: After reset no message is valid, the input is not ready while the channel is closed, and the first accepted word is written to address 0.
- R2: A word is accepted only when `in_valid` and `in_ready` are both high, and `in_ready` is low while `chan_open` is low. Each accepted word is written in the same cycle to `wr_addr` = {buffer index, word offset}, with the offset rising by one per word.
- R3: When the last word of a buffer is accepted, a release for that buffer is queued with a byte count of BUF_WORDS×(DATA_W/8). The next word goes to offset 0 of the next buffer index, wrapping from NUM_BUFS-1 to 0.
- R4: A `flush_req` pulse while the current buffer holds n>0 words queues a release of that buffer with n×(DATA_W/8) bytes. It holds `in_ready` low in that cycle, and the next word goes to offset 0 of the next buffer.
- R5: A `flush_req` while the current buffer holds no words has no effect: no message, and the next word still goes to the same address.
- R6: While NUM_BUFS buffers are released and not yet freed, `in_ready` is low.
- R7: A free command (`free_valid` with `free_idx`) unlocks a buffer only if it names the oldest released, unfreed buffer. Any other free command is ignored.
- R8: When NONEMPTY_EN is 1, accepting a word while the current buffer is empty and no buffer is locked queues one not-empty notice. When NONEMPTY_EN is 0, no such notice is ever sent.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_kind`, `msg_buf` and `msg_bytes` hold their values. A queued release blocks further input until it has been loaded into the message output.
- R10: When a release and a not-empty notice are both waiting for the output register, the release is presented first.
- R11: When `sync_mode` is high, a word is accepted only while the request credit is at least DATA_W/8 bytes. `req_valid` adds `req_bytes` to the credit, and each accepted word removes DATA_W/8.
- R12: `msg_kind` 0 means release and 1 means not-empty. A release carries a byte count between 1 and BUF_WORDS×(DATA_W/8). A not-empty notice carries `msg_buf` = 0 and `msg_bytes` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_open | input | 1 | Channel is open; gates the input |
| sync_mode | input | 1 | 1 = accept only against request credit |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word can be taken this cycle |
| in_data | input | DATA_W | Input word |
| req_valid | input | 1 | Adds `req_bytes` to the request credit |
| req_bytes | input | CREDIT_W | Bytes requested by the host |
| wr_en | output | 1 | Buffer memory write strobe |
| wr_addr | output | log2(NUM_BUFS)+log2(BUF_WORDS) | Word address {buffer, offset} |
| wr_data | output | DATA_W | Word written |
| flush_req | input | 1 | Host asks for early release of the current buffer |
| free_valid | input | 1 | Host free command strobe |
| free_idx | input | log2(NUM_BUFS) | Buffer named by the free command |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message sink accepts |
| msg_kind | output | 1 | 0 release, 1 not-empty |
| msg_buf | output | log2(NUM_BUFS) | Released buffer index |
| msg_bytes | output | log2(BUF_WORDS×DATA_W/8+1) | Valid bytes in the released buffer |

## Verification
Two pairs of events can land on the same edge. In the first, the final word of a buffer is accepted in the same cycle as a free command for the oldest locked buffer, so the locked count must rise and fall at once. In the second, a not-empty notice and a release are queued behind a stalled message output. The bench sets these up on purpose: it drives the free command together with the completing word, and it holds `msg_ready` low across a word and a flush. It judges both cases with a cycle-level reference model, which predicts `in_ready`, the write address and the message register on every clock. It also checks the exact order in which messages are delivered.

// File: rtl/up_ring_pkg.sv
package up_ring_pkg;

  typedef enum logic {
    MSG_RELEASE  = 1'b0,
    MSG_NONEMPTY = 1'b1
  } msg_kind_e;

  function automatic int bytes_per_word(input int width);
    return width / 8;
  endfunction

endpackage

// File: rtl/up_ring_tracker.sv
module up_ring_tracker #(
  parameter int NUM_BUFS  = 4,
  parameter int BUF_WORDS = 4,
  localparam int IDX_W    = $clog2(NUM_BUFS),
  localparam int OFF_W    = $clog2(BUF_WORDS),
  localparam int CNT_W    = IDX_W + 1,
  localparam int WORDS_W  = OFF_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_fire,
  input  logic               flush_req,
  input  logic               free_valid,
  input  logic [IDX_W-1:0]   free_idx,
  output logic [IDX_W-1:0]   cur_buf,
  output logic [OFF_W-1:0]   cur_off,
  output logic               has_room,
  output logic               chan_empty,
  output logic               rel_fire,
  output logic [IDX_W-1:0]   rel_idx,
  output logic [WORDS_W-1:0] rel_words
);

  logic [CNT_W-1:0] locked_cnt;
  logic [IDX_W-1:0] oldest;
  logic             full_done;
  logic             part_done;
  logic             free_ok;

  // the oldest locked buffer sits locked_cnt slots behind the fill buffer
  assign oldest     = cur_buf - locked_cnt[IDX_W-1:0];
  assign full_done  = wr_fire && (cur_off == OFF_W'(BUF_WORDS - 1));
  assign part_done  = flush_req && (cur_off != '0);
  assign rel_fire   = full_done || part_done;
  assign rel_idx    = cur_buf;
  assign rel_words  = full_done ? WORDS_W'(BUF_WORDS) : {1'b0, cur_off};
  assign free_ok    = free_valid && (locked_cnt != '0) && (free_idx == oldest);
  assign has_room   = (locked_cnt != CNT_W'(NUM_BUFS));
  assign chan_empty = (cur_off == '0) && (locked_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_buf    <= '0;
      cur_off    <= '0;
      locked_cnt <= '0;
    end else begin
      if (rel_fire) begin
        cur_buf <= cur_buf + IDX_W'(1);
        cur_off <= '0;
      end else if (wr_fire) begin
        cur_off <= cur_off + OFF_W'(1);
      end
      locked_cnt <= locked_cnt + CNT_W'(rel_fire) - CNT_W'(free_ok);
    end
  end

endmodule

// File: rtl/up_credit_gate.sv
module up_credit_gate #(
  parameter int CREDIT_W = 16,
  parameter int BPW      = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [CREDIT_W-1:0] req_bytes,
  input  logic                take,
  output logic                credit_ok
);

  logic [CREDIT_W-1:0] credit;
  logic [CREDIT_W-1:0] add_val;
  logic [CREDIT_W-1:0] sub_val;

  assign add_val   = req_valid ? req_bytes : '0;
  assign sub_val   = take ? CREDIT_W'(BPW) : '0;
  assign credit_ok = (credit >= CREDIT_W'(BPW));

  always_ff @(posedge clk) begin
    if (!rst_n) credit <= '0;
    else        credit <= credit + add_val - sub_val;
  end

endmodule

// File: rtl/up_msg_queue.sv
module up_msg_queue
  import up_ring_pkg::*;
#(
  parameter int IDX_W   = 2,
  parameter int BYTES_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rel_fire,
  input  logic [IDX_W-1:0]   rel_idx,
  input  logic [BYTES_W-1:0] rel_bytes,
  input  logic               ne_fire,
  input  logic               msg_ready,
  output logic               rel_pend,
  output logic               msg_valid,
  output logic               msg_kind,
  output logic [IDX_W-1:0]   msg_buf,
  output logic [BYTES_W-1:0] msg_bytes
);

  logic [IDX_W-1:0]   relq_idx;
  logic [BYTES_W-1:0] relq_bytes;
  logic               ne_pend;
  logic               load;
  msg_kind_e          out_kind;

  assign load     = !msg_valid || msg_ready;
  assign msg_kind = out_kind;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_pend   <= 1'b0;
      relq_idx   <= '0;
      relq_bytes <= '0;
      ne_pend    <= 1'b0;
      msg_valid  <= 1'b0;
      out_kind   <= MSG_RELEASE;
      msg_buf    <= '0;
      msg_bytes  <= '0;
    end else begin
      if (load) begin
        if (rel_pend) begin
          msg_valid <= 1'b1;
          out_kind  <= MSG_RELEASE;
          msg_buf   <= relq_idx;
          msg_bytes <= relq_bytes;
          rel_pend  <= 1'b0;
        end else if (ne_pend) begin
          msg_valid <= 1'b1;
          out_kind  <= MSG_NONEMPTY;
          msg_buf   <= '0;
          msg_bytes <= '0;
          ne_pend   <= 1'b0;
        end else begin
          msg_valid <= 1'b0;
        end
      end
      if (rel_fire) begin
        rel_pend   <= 1'b1;
        relq_idx   <= rel_idx;
        relq_bytes <= rel_bytes;
      end
      if (ne_fire) ne_pend <= 1'b1;
    end
  end

endmodule

// File: rtl/up_ring_mgr.sv
module up_ring_mgr
  import up_ring_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int NUM_BUFS    = 4,
  parameter int BUF_WORDS   = 4,
  parameter int CREDIT_W    = 16,
  parameter bit NONEMPTY_EN = 1'b1,
  localparam int BPW        = bytes_per_word(DATA_W),
  localparam int IDX_W      = $clog2(NUM_BUFS),
  localparam int OFF_W      = $clog2(BUF_WORDS),
  localparam int ADDR_W     = IDX_W + OFF_W,
  localparam int WORDS_W    = OFF_W + 1,
  localparam int BYTES_W    = $clog2(BUF_WORDS * BPW + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                chan_open,
  input  logic                sync_mode,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_data,
  input  logic                req_valid,
  input  logic [CREDIT_W-1:0] req_bytes,
  output logic                wr_en,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [DATA_W-1:0]   wr_data,
  input  logic                flush_req,
  input  logic                free_valid,
  input  logic [IDX_W-1:0]    free_idx,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic                msg_kind,
  output logic [IDX_W-1:0]    msg_buf,
  output logic [BYTES_W-1:0]  msg_bytes
);

  logic               wr_fire;
  logic [IDX_W-1:0]   cur_buf;
  logic [OFF_W-1:0]   cur_off;
  logic               has_room;
  logic               chan_empty;
  logic               rel_fire;
  logic [IDX_W-1:0]   rel_idx;
  logic [WORDS_W-1:0] rel_words;
  logic [BYTES_W-1:0] rel_bytes;
  logic               rel_pend;
  logic               credit_ok;
  logic               ne_fire;

  assign in_ready = chan_open && has_room && !rel_pend && !flush_req
                    && (!sync_mode || credit_ok);
  assign wr_fire  = in_valid && in_ready;
  assign wr_en    = wr_fire;
  assign wr_addr  = {cur_buf, cur_off};
  assign wr_data  = in_data;
  assign ne_fire  = NONEMPTY_EN && wr_fire && chan_empty;

  // word count to byte count by the configured word width
  generate
    if (DATA_W == 32) begin : g_bytes32
      assign rel_bytes = BYTES_W'({rel_words, 2'b00});
    end else if (DATA_W == 16) begin : g_bytes16
      assign rel_bytes = BYTES_W'({rel_words, 1'b0});
    end else begin : g_bytes8
      assign rel_bytes = BYTES_W'(rel_words);
    end
  endgenerate

  up_ring_tracker #(
    .NUM_BUFS (NUM_BUFS),
    .BUF_WORDS(BUF_WORDS)
  ) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_fire   (wr_fire),
    .flush_req (flush_req),
    .free_valid(free_valid),
    .free_idx  (free_idx),
    .cur_buf   (cur_buf),
    .cur_off   (cur_off),
    .has_room  (has_room),
    .chan_empty(chan_empty),
    .rel_fire  (rel_fire),
    .rel_idx   (rel_idx),
    .rel_words (rel_words)
  );

  up_credit_gate #(
    .CREDIT_W(CREDIT_W),
    .BPW     (BPW)
  ) u_credit (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_bytes(req_bytes),
    .take     (wr_fire && sync_mode),
    .credit_ok(credit_ok)
  );

  up_msg_queue #(
    .IDX_W  (IDX_W),
    .BYTES_W(BYTES_W)
  ) u_msg (
    .clk      (clk),
    .rst_n    (rst_n),
    .rel_fire (rel_fire),
    .rel_idx  (rel_idx),
    .rel_bytes(rel_bytes),
    .ne_fire  (ne_fire),
    .msg_ready(msg_ready),
    .rel_pend (rel_pend),
    .msg_valid(msg_valid),
    .msg_kind (msg_kind),
    .msg_buf  (msg_buf),
    .msg_bytes(msg_bytes)
  );

endmodule

// File: rtl/up_ring_chk.sv
module up_ring_chk #(
  parameter int DATA_W      = 16,
  parameter int NUM_BUFS    = 4,
  parameter int BUF_WORDS   = 4,
  parameter bit NONEMPTY_EN = 1'b1,
  localparam int BPW        = DATA_W / 8,
  localparam int IDX_W      = $clog2(NUM_BUFS),
  localparam int BYTES_W    = $clog2(BUF_WORDS * BPW + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               chan_open,
  input logic               flush_req,
  input logic               in_ready,
  input logic               wr_en,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic               msg_kind,
  input logic [IDX_W-1:0]   msg_buf,
  input logic [BYTES_W-1:0] msg_bytes
);

  assert_closed_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_open |-> !wr_en);

  assert_flush_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> !in_ready);

  assert_msg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_kind)
                                   && $stable(msg_buf) && $stable(msg_bytes)));

  assert_rel_bytes_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_kind) |-> (msg_bytes != '0
                                  && msg_bytes <= BYTES_W'(BUF_WORDS * BPW)));

  assert_ne_fields_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind) |-> (msg_bytes == '0 && msg_buf == '0));

  assert_ne_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !NONEMPTY_EN) |-> !msg_kind);

endmodule

bind up_ring_mgr up_ring_chk #(
  .DATA_W     (DATA_W),
  .NUM_BUFS   (NUM_BUFS),
  .BUF_WORDS  (BUF_WORDS),
  .NONEMPTY_EN(NONEMPTY_EN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .chan_open(chan_open),
  .flush_req(flush_req),
  .in_ready (in_ready),
  .wr_en    (wr_en),
  .msg_valid(msg_valid),
  .msg_ready(msg_ready),
  .msg_kind (msg_kind),
  .msg_buf  (msg_buf),
  .msg_bytes(msg_bytes)
);

// File: tb/up_ring_mgr_tb.sv
module up_ring_mgr_tb;

  localparam int DW  = 16;
  localparam int NB  = 4;
  localparam int BW  = 4;
  localparam int CW  = 16;
  localparam int BPW = DW / 8;
  localparam int IW  = $clog2(NB);
  localparam int AW  = IW + $clog2(BW);
  localparam int YW  = $clog2(BW * BPW + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chan_open = 1'b0, sync_mode = 1'b0, in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          req_valid = 1'b0;
  logic [CW-1:0] req_bytes = '0;
  logic          flush_req = 1'b0, free_valid = 1'b0, msg_ready = 1'b0;
  logic [IW-1:0] free_idx = '0;
  logic          in_ready, wr_en, msg_valid, msg_kind;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [IW-1:0] msg_buf;
  logic [YW-1:0] msg_bytes;

  always #2 clk = ~clk;

  up_ring_mgr #(.DATA_W(DW), .NUM_BUFS(NB), .BUF_WORDS(BW), .CREDIT_W(CW),
                .NONEMPTY_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .chan_open(chan_open), .sync_mode(sync_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .req_valid(req_valid), .req_bytes(req_bytes), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .flush_req(flush_req),
    .free_valid(free_valid), .free_idx(free_idx), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_kind(msg_kind), .msg_buf(msg_buf),
    .msg_bytes(msg_bytes));

  int checks = 0, errors = 0, cycles = 0;
  // staged stimulus
  bit nx_open, nx_sync, nx_valid, nx_flush, nx_free, nx_req, nx_mrdy;
  int nx_free_idx, nx_req_bytes, nx_data = 1;
  // reference model
  int m_buf, m_off, m_rel, m_credit;
  int relq[$];
  bit m_ne, mo_valid;
  int mo_kind, mo_buf, mo_bytes;
  int got_q[$];
  bit last_fire;
  int last_addr;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    bit ready, fire, empty, full, part, rel, freeok;
    int rbytes, rbuf, oldest;
    @(negedge clk);
    chan_open = nx_open; sync_mode = nx_sync; in_valid = nx_valid;
    in_data = DW'(nx_data); flush_req = nx_flush; free_valid = nx_free;
    free_idx = IW'(nx_free_idx); req_valid = nx_req; req_bytes = CW'(nx_req_bytes);
    msg_ready = nx_mrdy;
    #1;
    ready = nx_open && (m_rel < NB) && (relq.size() == 0) && !nx_flush
            && (!nx_sync || m_credit >= BPW);
    fire = nx_valid && ready;
    chk(in_ready === ready, "R6/R11 in_ready", int'(in_ready), int'(ready));
    chk(wr_en === fire, "R2 wr_en", int'(wr_en), int'(fire));
    if (fire) begin
      chk(int'(wr_addr) == m_buf * BW + m_off, "R2/R3 wr_addr", int'(wr_addr), m_buf * BW + m_off);
      chk(int'(wr_data) == nx_data, "R2 wr_data", int'(wr_data), nx_data);
    end
    chk(msg_valid === mo_valid, "R9 msg_valid", int'(msg_valid), int'(mo_valid));
    if (mo_valid) begin
      chk(int'(msg_kind) == mo_kind, "R10/R12 msg_kind", int'(msg_kind), mo_kind);
      chk(int'(msg_buf) == mo_buf, "R3 msg_buf", int'(msg_buf), mo_buf);
      chk(int'(msg_bytes) == mo_bytes, "R4/R12 msg_bytes", int'(msg_bytes), mo_bytes);
    end
    if (msg_valid && msg_ready)
      got_q.push_back((int'(msg_kind) << 16) | (int'(msg_buf) << 8) | int'(msg_bytes));
    last_fire = fire;
    if (fire) begin last_addr = int'(wr_addr); nx_data++; end
    // model next state
    empty  = (m_off == 0) && (m_rel == 0);
    full   = fire && (m_off == BW - 1);
    part   = nx_flush && (m_off != 0);
    rel    = full || part;
    rbytes = full ? BW * BPW : m_off * BPW;
    rbuf   = m_buf;
    oldest = (m_buf - m_rel + NB) % NB;
    freeok = nx_free && (m_rel > 0) && (nx_free_idx == oldest);
    if (!mo_valid || nx_mrdy) begin
      if (relq.size() > 0) begin
        int v = relq.pop_front();
        mo_valid = 1; mo_kind = 0; mo_buf = v >> 8; mo_bytes = v & 255;
      end else if (m_ne) begin
        mo_valid = 1; mo_kind = 1; mo_buf = 0; mo_bytes = 0; m_ne = 0;
      end else mo_valid = 0;
    end
    if (rel) relq.push_back((rbuf << 8) | rbytes);
    if (fire && empty) m_ne = 1;
    if (rel) begin m_buf = (m_buf + 1) % NB; m_off = 0; end
    else if (fire) m_off++;
    m_rel = m_rel + int'(rel) - int'(freeok);
    m_credit = m_credit + (nx_req ? nx_req_bytes : 0) - ((fire && nx_sync) ? BPW : 0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic send(int n);
    int cnt = 0;
    nx_valid = 1;
    while (cnt < n) begin
      cyc();
      if (last_fire) cnt++;
    end
    nx_valid = 0;
  endtask

  task automatic do_free(int idx);
    nx_free = 1; nx_free_idx = idx;
    cyc();
    nx_free = 0;
  endtask

  task automatic do_flush();
    nx_flush = 1;
    cyc();
    nx_flush = 0;
  endtask

  task automatic expect_msg(int kind, int b, int by, string tag);
    int e = (kind << 16) | (b << 8) | by;
    if (got_q.size() == 0) chk(1'b0, tag, -1, e);
    else begin
      int a = got_q.pop_front();
      chk(a == e, tag, a, e);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", cycles, 50000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int fires, qs;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    #1;
    chk(msg_valid === 1'b0, "R1 msg_valid after reset", int'(msg_valid), 0);
    chk(in_ready === 1'b0, "R1 in_ready closed", int'(in_ready), 0);
    idle(2);
    nx_open = 1; nx_mrdy = 1;
    // R1 R3 R8: first word address, full buffer release, not-empty first
    send(1);
    chk(last_addr == 0, "R1 first address", last_addr, 0);
    send(3); idle(4);
    expect_msg(1, 0, 0, "R8 not-empty notice");
    expect_msg(0, 0, BW * BPW, "R3 full release buf0");
    // R4 partial flush
    send(2); do_flush(); idle(3);
    expect_msg(0, 1, 2 * BPW, "R4 partial release buf1");
    // R5 flush with empty buffer
    qs = got_q.size();
    do_flush(); idle(4);
    chk(got_q.size() == qs, "R5 no message on empty flush", got_q.size(), qs);
    send(1);
    chk(last_addr == 2 * BW, "R5 address unchanged after empty flush", last_addr, 2 * BW);
    // R6 backpressure with all buffers locked
    send(3); send(4); idle(4);
    expect_msg(0, 2, BW * BPW, "R3 release buf2");
    expect_msg(0, 3, BW * BPW, "R3 release buf3 wraps");
    chk(in_ready === 1'b0, "R6 ring full stalls", int'(in_ready), 0);
    // R7 out-of-order free ignored
    do_free(1); idle(2);
    chk(in_ready === 1'b0, "R7 wrong free ignored", int'(in_ready), 0);
    do_free(0); idle(1);
    chk(in_ready === 1'b1, "R7 oldest free unlocks", int'(in_ready), 1);
    // free and full release on the same edge
    send(3);
    nx_valid = 1; nx_free = 1; nx_free_idx = 1;
    cyc();
    chk(last_fire == 1'b1, "R3 completing word with free", int'(last_fire), 1);
    nx_valid = 0; nx_free = 0;
    idle(3);
    chk(in_ready === 1'b1, "R7 count after joint release/free", int'(in_ready), 1);
    expect_msg(0, 0, BW * BPW, "R3 release buf0 after wrap");
    // R10 priority of release over not-empty
    do_free(2); do_free(3); do_free(0); idle(1);
    nx_mrdy = 0;
    send(1); idle(2);
    do_flush(); idle(2);
    nx_mrdy = 1; cyc(); nx_mrdy = 0; idle(2);
    do_free(1); idle(1);
    send(1); idle(1); do_flush(); idle(2);
    nx_mrdy = 1; idle(6);
    expect_msg(1, 0, 0, "R8 not-empty after empty ring");
    expect_msg(0, 1, BPW, "R9 held release delivered");
    expect_msg(0, 2, BPW, "R10 release before not-empty");
    expect_msg(1, 0, 0, "R10 not-empty after release");
    chk(got_q.size() == 0, "R9 no extra messages", got_q.size(), 0);
    // R11 synchronous credits
    do_free(1); do_free(2); idle(1);
    nx_sync = 1; nx_valid = 1; idle(2);
    chk(in_ready === 1'b0, "R11 no credit stalls", int'(in_ready), 0);
    nx_req = 1; nx_req_bytes = 3; cyc(); nx_req = 0;
    fires = 0;
    for (int i = 0; i < 4; i++) begin cyc(); if (last_fire) fires++; end
    chk(fires == 1, "R11 three bytes take one word", fires, 1);
    nx_req = 1; nx_req_bytes = 4; cyc(); nx_req = 0;
    fires = 0;
    for (int i = 0; i < 6; i++) begin cyc(); if (last_fire) fires++; end
    chk(fires == 2, "R11 four more bytes take two words", fires, 2);
    // R2 closed channel
    nx_sync = 0; nx_open = 0; idle(2);
    chk(in_ready === 1'b0, "R2 closed channel", int'(in_ready), 0);
    chk(wr_en === 1'b0, "R2 no write when closed", int'(wr_en), 0);
    nx_valid = 0; idle(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule